// File: doc/BRIEF.md
# Serial Debug Port Shifter

This block connects an external debug tool to a CPU core over a three-wire synchronous serial link: a debug clock, a serial input and a serial output. The tool sends frames. Each frame opens with a start bit of 1, then a mode bit, then a control bit. Mode 0 selects a long frame with a 32-bit payload: control 0 marks a CPU instruction and control 1 marks CPU data. Mode 1 selects a short frame with a 7-bit payload: control 0 marks a trap-enable value and control 1 marks a port command. All payloads travel most significant bit first. Each decoded payload reaches the CPU as a one-cycle strobe with a held payload bus.

While the tool clocks a frame in, the block clocks a response frame out. The response starts with a ready bit, which is 0 while the CPU is waiting for a word. A 2-bit status follows, then 32 data bits. The status reports, in priority order, data that the CPU has placed in the port's data register, an instruction/data sequence mismatch, a pending CPU interrupt, or nothing.

Both serial inputs are resynchronised into the system clock domain. Input bits are taken on rising debug-clock edges, and the output changes after falling edges.

Top module: `dbgp_serial_port`

## Requirements
- R1: After reset, `dbg_sdo` is 1 while `cpu_rd_req` is low, all strobes and `fdl_active` are 0, and the first response carries status 11 (null) with 32 zero data bits.
- R2: Between frames, `dbg_sdo` equals the inverse of `cpu_rd_req`: it is 0 (ready) while the CPU requests a word and 1 otherwise.
- R3: A long frame (start 1, mode 0, control 0, 32 payload bits MSB first) received while `cpu_want_data` is 0 produces exactly one single-cycle `instr_vld` pulse, with the payload on `word_o`.
- R4: A long frame with control 1 received while `cpu_want_data` is 1 produces exactly one `data_vld` pulse, with the payload on `word_o`.
- R5: A long frame whose control bit differs from `cpu_want_data` produces no strobe. The next response carries status 01 (sequence error) with zero data.
- R6: A short frame (start 1, mode 1, control 0, 7 payload bits) produces one `trap_vld` pulse, with the value on `trap_o`.
- R7: In a short frame with control 1, command 0011000 pulses `brk_negate`, 0011001 pulses `core_reset`, 0011010 sets `fdl_active` and 0011011 clears it. Command 0011111 is a no-operation, and any other value is ignored; neither pulses a strobe nor changes `fdl_active`.
- R8: On successive sampling points after the ready bit, the response gives status bit 1, status bit 0, then data bit 31 down to bit 0. The data bits are zero unless the status is 00.
- R9: Status priority is valid data (00), then sequence error (01), then interrupt (10), then null (11). An interrupt that is pending while valid data is reported appears in a later frame.
- R10: Sequence-error and interrupt status clear once reported. Valid-data status clears only after a long frame. A short frame carries the ready bit, the status and data bits 31 to 25, and leaves valid data pending.
- R11: At most one CPU-side strobe is high in any cycle. Strobes occur only just after a frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_sck | input | 1 | Debug clock from the tool |
| dbg_sdi | input | 1 | Serial data from the tool |
| dbg_sdo | output | 1 | Serial response to the tool |
| cpu_rd_req | input | 1 | CPU is waiting for a word from the port |
| cpu_want_data | input | 1 | CPU expects data (1) or an instruction (0) |
| cpu_irq | input | 1 | Pulse: CPU interrupt recognised |
| dpdr_load | input | 1 | Pulse: CPU writes the port data register |
| dpdr_data | input | 32 | Data written by the CPU |
| instr_vld | output | 1 | Pulse: instruction delivered |
| data_vld | output | 1 | Pulse: data word delivered |
| word_o | output | 32 | Delivered instruction or data word |
| trap_vld | output | 1 | Pulse: trap-enable value delivered |
| trap_o | output | 7 | Trap-enable value |
| brk_negate | output | 1 | Pulse: negate breakpoint requests |
| core_reset | output | 1 | Pulse: reset the processor |
| fdl_active | output | 1 | Fast-download mode active |

## Verification
A receive bit counter that slips shows within one frame. A short frame is then taken as long, or a long frame as short. Either way the strobe for that frame is missing or carries a shifted word. A wrong status flag, or a missed clear, shows as a wrong status code in the very next response. A flag that is never cleared shows in the frame after that, when the status should have moved down the priority order. A transmit shift register that is misaligned by one position corrupts every response bit from the status onward. The effect can be seen at the tool's next sampling edge.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
   typedef enum logic [1:0] {
      ST_VALID  = 2'b00,
      ST_SEQERR = 2'b01,
      ST_IRQ    = 2'b10,
      ST_NULL   = 2'b11
   } dbgp_status_e;

   localparam logic [6:0] CMD_BRK_NEG  = 7'b0011000;
   localparam logic [6:0] CMD_CORE_RST = 7'b0011001;
   localparam logic [6:0] CMD_FDL_ON   = 7'b0011010;
   localparam logic [6:0] CMD_FDL_OFF  = 7'b0011011;
   localparam logic [6:0] CMD_NOP      = 7'b0011111;
endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   logic [CHAIN_W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbgp_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[W-1:0], d};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[CHAIN_W-W-1:0], d};
         end
      end
   endgenerate

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/dbgp_rx.sv
module dbgp_rx #(
   parameter int WORD_W  = 32,
   parameter int SHORT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              sdi_bit,
   output logic              busy,
   output logic              frame_start,
   output logic              frame_done,
   output logic              mode_o,
   output logic              ctrl_o,
   output logic [WORD_W-1:0] payload_o
);
   localparam int LONG_LAST  = WORD_W + 1;
   localparam int SHORT_LAST = SHORT_W + 1;
   localparam int CNT_W      = $clog2(WORD_W + 2);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_idx;

   assign last_idx = mode_o ? CNT_W'(SHORT_LAST) : CNT_W'(LONG_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         frame_start <= 1'b0;
         frame_done  <= 1'b0;
         mode_o      <= 1'b0;
         ctrl_o      <= 1'b0;
         payload_o   <= '0;
         cnt         <= '0;
      end else begin
         frame_start <= 1'b0;
         frame_done  <= 1'b0;
         if (bit_stb) begin
            if (!busy) begin
               if (sdi_bit) begin
                  busy        <= 1'b1;
                  frame_start <= 1'b1;
                  cnt         <= '0;
               end
            end else begin
               payload_o <= {payload_o[WORD_W-2:0], sdi_bit};
               if (cnt == CNT_W'(0)) mode_o <= sdi_bit;
               if (cnt == CNT_W'(1)) ctrl_o <= sdi_bit;
               if (cnt == last_idx) begin
                  busy       <= 1'b0;
                  frame_done <= 1'b1;
               end
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/dbgp_tx.sv
module dbgp_tx
   import dbgp_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_stb,
   input  logic              busy,
   input  logic              frame_start,
   input  logic              frame_done,
   input  logic              short_frame,
   input  logic              cpu_rd_req,
   input  logic              dpdr_load,
   input  logic [WORD_W-1:0] dpdr_data,
   input  logic              irq_set,
   input  logic              seq_set,
   output logic              sdo
);
   localparam int OSR_W = WORD_W + 2;

   logic              dval_q, seq_q, irq_q;
   logic [WORD_W-1:0] dreg_q;
   logic [OSR_W-1:0]  osr_q;
   dbgp_status_e      rep_q, status_now;

   always_comb begin
      if (dval_q)     status_now = ST_VALID;
      else if (seq_q) status_now = ST_SEQERR;
      else if (irq_q) status_now = ST_IRQ;
      else            status_now = ST_NULL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dval_q <= 1'b0;
         seq_q  <= 1'b0;
         irq_q  <= 1'b0;
         dreg_q <= '0;
         osr_q  <= '0;
         rep_q  <= ST_NULL;
         sdo    <= 1'b1;
      end else begin
         if (frame_done) begin
            case (rep_q)
               ST_VALID:  if (!short_frame) dval_q <= 1'b0;
               ST_SEQERR: seq_q <= 1'b0;
               ST_IRQ:    irq_q <= 1'b0;
               default:   ;
            endcase
         end
         if (dpdr_load) begin
            dval_q <= 1'b1;
            dreg_q <= dpdr_data;
         end
         if (seq_set) seq_q <= 1'b1;
         if (irq_set) irq_q <= 1'b1;

         if (frame_start) begin
            rep_q <= status_now;
            osr_q <= {status_now, (status_now == ST_VALID) ? dreg_q : {WORD_W{1'b0}}};
         end else if (busy && fall_stb) begin
            sdo   <= osr_q[OSR_W-1];
            osr_q <= {osr_q[OSR_W-2:0], 1'b0};
         end

         if (!busy) sdo <= !cpu_rd_req;
      end
   end
endmodule

// File: rtl/dbgp_decode.sv
module dbgp_decode
   import dbgp_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int SHORT_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_done,
   input  logic               mode,
   input  logic               ctrl,
   input  logic [WORD_W-1:0]  payload,
   input  logic               want_data,
   output logic               seq_err,
   output logic               instr_vld,
   output logic               data_vld,
   output logic [WORD_W-1:0]  word_o,
   output logic               trap_vld,
   output logic [SHORT_W-1:0] trap_o,
   output logic               brk_negate,
   output logic               core_reset,
   output logic               fdl_active
);
   logic [SHORT_W-1:0] cmd;

   assign cmd     = payload[SHORT_W-1:0];
   assign seq_err = frame_done && !mode && (ctrl != want_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_vld  <= 1'b0;
         data_vld   <= 1'b0;
         word_o     <= '0;
         trap_vld   <= 1'b0;
         trap_o     <= '0;
         brk_negate <= 1'b0;
         core_reset <= 1'b0;
         fdl_active <= 1'b0;
      end else begin
         instr_vld  <= 1'b0;
         data_vld   <= 1'b0;
         trap_vld   <= 1'b0;
         brk_negate <= 1'b0;
         core_reset <= 1'b0;
         if (frame_done) begin
            if (!mode) begin
               if (!seq_err) begin
                  word_o <= payload;
                  if (ctrl) data_vld  <= 1'b1;
                  else      instr_vld <= 1'b1;
               end
            end else if (!ctrl) begin
               trap_vld <= 1'b1;
               trap_o   <= cmd;
            end else begin
               case (cmd)
                  SHORT_W'(CMD_BRK_NEG):  brk_negate <= 1'b1;
                  SHORT_W'(CMD_CORE_RST): core_reset <= 1'b1;
                  SHORT_W'(CMD_FDL_ON):   fdl_active <= 1'b1;
                  SHORT_W'(CMD_FDL_OFF):  fdl_active <= 1'b0;
                  SHORT_W'(CMD_NOP):      ;
                  default:                ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/dbgp_serial_port.sv
module dbgp_serial_port #(
   parameter int WORD_W      = 32,
   parameter int SHORT_W     = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dbg_sck,
   input  logic               dbg_sdi,
   output logic               dbg_sdo,
   input  logic               cpu_rd_req,
   input  logic               cpu_want_data,
   input  logic               cpu_irq,
   input  logic               dpdr_load,
   input  logic [WORD_W-1:0]  dpdr_data,
   output logic               instr_vld,
   output logic               data_vld,
   output logic [WORD_W-1:0]  word_o,
   output logic               trap_vld,
   output logic [SHORT_W-1:0] trap_o,
   output logic               brk_negate,
   output logic               core_reset,
   output logic               fdl_active
);
   localparam int SYNC_W = 2;

   generate
      if (SHORT_W < 7 || SHORT_W >= WORD_W) begin : g_bad_widths
         $error("dbgp_serial_port: need 7 <= SHORT_W < WORD_W");
      end
   endgenerate

   logic [SYNC_W-1:0] sync_q;
   logic              sck_d, rise_stb, fall_stb;
   logic              busy, frame_start, frame_done, mode, ctrl, seq_err;
   logic [WORD_W-1:0] payload;

   dbgp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({dbg_sck, dbg_sdi}), .q(sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sync_q[1];
   end

   assign rise_stb = sync_q[1] && !sck_d;
   assign fall_stb = !sync_q[1] && sck_d;

   dbgp_rx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_stb(rise_stb), .sdi_bit(sync_q[0]),
      .busy(busy), .frame_start(frame_start), .frame_done(frame_done),
      .mode_o(mode), .ctrl_o(ctrl), .payload_o(payload)
   );

   dbgp_decode #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .mode(mode),
      .ctrl(ctrl), .payload(payload), .want_data(cpu_want_data),
      .seq_err(seq_err), .instr_vld(instr_vld), .data_vld(data_vld),
      .word_o(word_o), .trap_vld(trap_vld), .trap_o(trap_o),
      .brk_negate(brk_negate), .core_reset(core_reset), .fdl_active(fdl_active)
   );

   dbgp_tx #(.WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .busy(busy),
      .frame_start(frame_start), .frame_done(frame_done), .short_frame(mode),
      .cpu_rd_req(cpu_rd_req), .dpdr_load(dpdr_load), .dpdr_data(dpdr_data),
      .irq_set(cpu_irq), .seq_set(seq_err), .sdo(dbg_sdo)
   );
endmodule

// File: rtl/dbgp_serial_port_chk.sv
module dbgp_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic sdo,
   input logic busy,
   input logic fall_stb,
   input logic frame_done,
   input logic instr_vld,
   input logic data_vld,
   input logic trap_vld,
   input logic brk_negate,
   input logic core_reset,
   input logic fdl_active
);
   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({instr_vld, data_vld, trap_vld, brk_negate, core_reset}));

   assert_strobe_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld || data_vld || trap_vld || brk_negate || core_reset) |-> $past(frame_done));

   assert_instr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_vld |=> !instr_vld);

   assert_data_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld |=> !data_vld);

   assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset |=> !core_reset);

   assert_fdl_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fdl_active) |-> $past(frame_done));

   assert_sdo_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(fall_stb)) |-> $stable(sdo));
endmodule

bind dbgp_serial_port dbgp_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sdo(dbg_sdo), .busy(busy), .fall_stb(fall_stb),
   .frame_done(frame_done), .instr_vld(instr_vld), .data_vld(data_vld),
   .trap_vld(trap_vld), .brk_negate(brk_negate), .core_reset(core_reset),
   .fdl_active(fdl_active)
);

// File: tb/dbgp_serial_port_bench.sv
module dbgp_serial_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_sck = 1'b0, dbg_sdi = 1'b0, dbg_sdo;
   logic        cpu_rd_req = 1'b0, cpu_want_data = 1'b0, cpu_irq = 1'b0;
   logic        dpdr_load = 1'b0;
   logic [31:0] dpdr_data = '0;
   logic        instr_vld, data_vld, trap_vld, brk_negate, core_reset, fdl_active;
   logic [31:0] word_o;
   logic [6:0]  trap_o;

   int n_checks = 0, n_fail = 0;
   int n_instr = 0, n_data = 0, n_trap = 0, n_brk = 0, n_rst = 0;
   logic [31:0] last_word = '0;
   logic [6:0]  last_trap = '0;
   logic        finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbgp_serial_port u_dbgp_serial_port (
      .clk(clk), .rst_n(rst_n), .dbg_sck(dbg_sck), .dbg_sdi(dbg_sdi),
      .dbg_sdo(dbg_sdo), .cpu_rd_req(cpu_rd_req), .cpu_want_data(cpu_want_data),
      .cpu_irq(cpu_irq), .dpdr_load(dpdr_load), .dpdr_data(dpdr_data),
      .instr_vld(instr_vld), .data_vld(data_vld), .word_o(word_o),
      .trap_vld(trap_vld), .trap_o(trap_o), .brk_negate(brk_negate),
      .core_reset(core_reset), .fdl_active(fdl_active)
   );

   always @(negedge clk) begin
      if (instr_vld)  begin n_instr++; last_word = word_o; end
      if (data_vld)   begin n_data++;  last_word = word_o; end
      if (trap_vld)   begin n_trap++;  last_trap = trap_o; end
      if (brk_negate) n_brk++;
      if (core_reset) n_rst++;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   // Sends one frame; rsp[34] is the ready bit seen at the start-bit edge.
   task automatic send_frame(input logic mode, input logic ctrl, input logic [31:0] pay,
                             output logic [34:0] rsp);
      logic [34:0] bits;
      int n;
      bits = mode ? {1'b1, mode, ctrl, pay[6:0], 25'b0} : {1'b1, mode, ctrl, pay};
      n = mode ? 10 : 35;
      rsp = '0;
      for (int k = 0; k < n; k++) begin
         dbg_sck = 1'b0;
         dbg_sdi = bits[34-k];
         repeat (HALF_SCK) @(negedge clk);
         rsp[34-k] = dbg_sdo;
         dbg_sck = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
      end
      dbg_sck = 1'b0;
      dbg_sdi = 1'b0;
      repeat (20) @(negedge clk);
   endtask

   int sum0;
   logic [34:0] r;

   task automatic t_reset;
      check("R1 sdo idle high", dbg_sdo, 1);
      check("R1 outputs quiet", {instr_vld, data_vld, trap_vld, brk_negate, core_reset, fdl_active}, 0);
      cpu_rd_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R2 ready low", dbg_sdo, 0);
      cpu_rd_req = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 not ready high", dbg_sdo, 1);
      cpu_rd_req = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_instr;
      cpu_want_data = 1'b0;
      send_frame(1'b0, 1'b0, 32'hA5C3_1E7F, r);
      check("R3 instr count", n_instr, 1);
      check("R3 instr word", last_word, 32'hA5C3_1E7F);
      check("R1 null response", r, {1'b0, 2'b11, 32'h0});
   endtask

   task automatic t_data;
      cpu_want_data = 1'b1;
      send_frame(1'b0, 1'b1, 32'h0123_89AB, r);
      check("R4 data count", n_data, 1);
      check("R4 data word", last_word, 32'h0123_89AB);
      check("R3 no extra instr", n_instr, 1);
   endtask

   task automatic t_seq;
      cpu_want_data = 1'b0;
      sum0 = n_instr + n_data;
      send_frame(1'b0, 1'b1, 32'hDEAD_BEEF, r);
      check("R5 no strobe on mismatch", n_instr + n_data, sum0);
      pulse(cpu_irq);
      send_frame(1'b1, 1'b1, 32'h1F, r);
      check("R5 seq status", r[34:25], {1'b0, 2'b01, 7'b0});
      send_frame(1'b1, 1'b1, 32'h1F, r);
      check("R9 irq after seq", r[34:25], {1'b0, 2'b10, 7'b0});
      send_frame(1'b1, 1'b1, 32'h1F, r);
      check("R10 status cleared", r[34:25], {1'b0, 2'b11, 7'b0});
   endtask

   task automatic t_trap;
      send_frame(1'b1, 1'b0, 32'h5A, r);
      check("R6 trap count", n_trap, 1);
      check("R6 trap value", last_trap, 7'h5A);
   endtask

   task automatic t_cmds;
      send_frame(1'b1, 1'b1, 32'b0011000, r);
      check("R7 brk negate", n_brk, 1);
      send_frame(1'b1, 1'b1, 32'b0011001, r);
      check("R7 core reset", n_rst, 1);
      send_frame(1'b1, 1'b1, 32'b0011010, r);
      check("R7 fdl on", fdl_active, 1);
      sum0 = n_instr + n_data + n_trap + n_brk + n_rst;
      send_frame(1'b1, 1'b1, 32'h55, r);
      check("R7 reserved keeps fdl", fdl_active, 1);
      send_frame(1'b1, 1'b1, 32'b0011111, r);
      check("R7 nop keeps fdl", fdl_active, 1);
      check("R7 reserved/nop no strobes", n_instr + n_data + n_trap + n_brk + n_rst, sum0);
      send_frame(1'b1, 1'b1, 32'b0011011, r);
      check("R7 fdl off", fdl_active, 0);
   endtask

   task automatic t_valid;
      pulse(cpu_irq);
      dpdr_data = 32'hC0DE_F00D;
      pulse(dpdr_load);
      send_frame(1'b1, 1'b1, 32'h1F, r);
      check("R10 short frame valid", r[34:25], {1'b0, 2'b00, 7'b1100000});
      cpu_want_data = 1'b0;
      send_frame(1'b0, 1'b0, 32'h1111_2222, r);
      check("R8 long valid response", r, {1'b0, 2'b00, 32'hC0DE_F00D});
      check("R9 valid beats irq word", last_word, 32'h1111_2222);
      send_frame(1'b1, 1'b1, 32'h1F, r);
      check("R9 irq later", r[34:25], {1'b0, 2'b10, 7'b0});
      send_frame(1'b0, 1'b0, 32'h0, r);
      check("R8 null zero data", r, {1'b0, 2'b11, 32'h0});
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_instr();
      t_data();
      t_seq();
      t_trap();
      t_cmds();
      t_valid();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule